// File: doc/BRIEF.md
# Write Unlock Sequencer

This block guards a byte-wide nonvolatile store against writes that were never meant. Every write operation has to be opened by three command writes, each with a fixed address and data value. Only the data writes that follow a complete sequence are passed on to the page buffer. Protection is always on. When a sequence finishes, the page-load phase opens. Each accepted data write restarts a load window. When the window expires, the block signals that the load is over and then waits for the programming engine to report that it is done. After that, the next operation needs a new sequence.

A write that arrives without the sequence in front of it stores nothing. It still starts a timed dummy cycle, and while that cycle runs the block reports busy, so that reads act as status polls. The command writes themselves are marked as not stored. Their addresses stay ordinary storage locations, so a data write to one of them after a full sequence is stored as normal. The three command address/data pairs and the length of the load window are parameters.

Top module: `wp_unlock_seq`

## Requirements
- R1: After reset the block is locked and idle: `wr_allow`, `cmd_nostore`, `dummy_start`, `load_close` and `poll_busy` are all 0. A write that is not the first command is then treated as unprotected.
- R2: Three write events that match the command pairs in order (defaults 0x05555/0xAA, 0x02AAA/0x55, 0x05555/0xA0) each give `cmd_nostore`=1 and `wr_allow`=0 in the cycle of the event.
- R3: A write in the second or third command slot that does not match its pair returns the sequencer to idle. That write gives no output pulse, and the sequence has to restart from the first command.
- R4: After a complete sequence, every data write gives `wr_allow`=1, including writes to command addresses with command data.
- R5: In idle, a write event that is not the first command gives `dummy_start`=1, stores nothing (`wr_allow`=0), and makes the block busy from the next cycle.
- R6: While busy, write events give no output pulse. `prog_done` returns the block to idle in the next cycle. `prog_done` has no effect in any other state.
- R7: If LOAD_WIN cycles pass after the last accepted data write with no further write, `load_close` pulses in the last of those cycles and the block is busy from the next cycle.
- R8: If a sequence completes but no data write follows within LOAD_WIN cycles, the block relocks silently: no `load_close` pulse, no busy, and the next data write is unprotected.
- R9: Protection cannot be switched off. After programming completes, a data write without a new sequence starts a dummy cycle.
- R10: `poll_busy` is 1 for the whole dummy cycle and for the whole programming period, up to the cycle in which `prog_done` is seen.
- R11: Every data write accepted during the load phase restarts the load window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_evt | input | 1 | One-cycle qualified write event |
| wr_addr | input | AW | Address of the write event |
| wr_data | input | DW | Data of the write event |
| prog_done | input | 1 | Programming or dummy cycle finished |
| wr_allow | output | 1 | The current write goes to the page buffer |
| cmd_nostore | output | 1 | The current write is a command and is not stored |
| dummy_start | output | 1 | Start the timed dummy cycle for an unprotected write |
| load_close | output | 1 | The load window has expired; programming may begin |
| poll_busy | output | 1 | Dummy or programming period active; reads act as polls |

## Verification
A wrong sequencer state appears at the ports in the same cycle as the next write event. A stray unlock shows up as `wr_allow` where `dummy_start` was expected, and a missed step shows up the other way round, so every check drives a write and samples before the clock edge. Faults in the window counter appear only at the boundary: `load_close` one cycle too early or too late, or a silent relock that instead goes busy. For this reason the bench counts the window cycle by cycle. A busy state that is never released shows up as ignored writes after `prog_done`.

// File: rtl/wpu_pkg.sv
package wpu_pkg;

  typedef enum logic [2:0] {
    S_IDLE = 3'd0,
    S_GOT1 = 3'd1,
    S_GOT2 = 3'd2,
    S_OPEN = 3'd3,
    S_LOAD = 3'd4,
    S_BUSY = 3'd5
  } wpu_state_e;

  // Command slot that the sequencer expects in a given state.
  function automatic int unsigned slot_of(wpu_state_e s);
    case (s)
      S_GOT1:  return 1;
      S_GOT2:  return 2;
      default: return 0;
    endcase
  endfunction

  // State that follows a matching command write.
  function automatic wpu_state_e seq_advance(wpu_state_e s);
    case (s)
      S_IDLE:  return S_GOT1;
      S_GOT1:  return S_GOT2;
      default: return S_OPEN;
    endcase
  endfunction

endpackage

// File: rtl/wpu_step_match.sv
module wpu_step_match #(
  parameter int AW = 17,
  parameter int DW = 8,
  parameter int N_STEPS = 3,
  parameter logic [N_STEPS-1:0][AW-1:0] CMD_ADDR = '0,
  parameter logic [N_STEPS-1:0][DW-1:0] CMD_DATA = '0
) (
  input  logic [AW-1:0]      addr,
  input  logic [DW-1:0]      data,
  output logic [N_STEPS-1:0] hit
);

  for (genvar g = 0; g < N_STEPS; g++) begin : g_step
    assign hit[g] = (addr == CMD_ADDR[g]) && (data == CMD_DATA[g]);
  end

endmodule

// File: rtl/wpu_win_timer.sv
module wpu_win_timer #(
  parameter int LOAD_WIN = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic restart,
  output logic expire
);

  localparam int CW = (LOAD_WIN > 2) ? $clog2(LOAD_WIN) : 1;
  localparam logic [CW-1:0] LAST = CW'(LOAD_WIN - 1);

  logic [CW-1:0] cnt;

  assign expire = run && !restart && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n)              cnt <= '0;
    else if (!run || restart) cnt <= '0;
    else if (cnt != LAST)    cnt <= cnt + 1'b1;
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST);                                                  // R7
  AST_IDLE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt == '0));                                         // R8
  AST_RESTART_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !expire);                                          // R11

endmodule

// File: rtl/wp_unlock_seq.sv
module wp_unlock_seq #(
  parameter int AW = 17,
  parameter int DW = 8,
  parameter int LOAD_WIN = 16,
  parameter logic [2:0][AW-1:0] CMD_ADDR = {17'h05555, 17'h02AAA, 17'h05555},
  parameter logic [2:0][DW-1:0] CMD_DATA = {8'hA0, 8'h55, 8'hAA}
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_evt,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          prog_done,
  output logic          wr_allow,
  output logic          cmd_nostore,
  output logic          dummy_start,
  output logic          load_close,
  output logic          poll_busy
);
  import wpu_pkg::*;

  localparam int N_STEPS = 3;

  wpu_state_e state, state_nx;
  logic [N_STEPS-1:0] step_hit;
  logic win_run, win_restart, win_expire;
  logic slot_ok;

  wpu_step_match #(
    .AW(AW), .DW(DW), .N_STEPS(N_STEPS),
    .CMD_ADDR(CMD_ADDR), .CMD_DATA(CMD_DATA)
  ) i_match (
    .addr(wr_addr),
    .data(wr_data),
    .hit (step_hit)
  );

  assign win_run     = (state == S_OPEN) || (state == S_LOAD);
  assign win_restart = win_run && wr_evt;

  wpu_win_timer #(.LOAD_WIN(LOAD_WIN)) i_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (win_run),
    .restart(win_restart),
    .expire (win_expire)
  );

  assign slot_ok = step_hit[slot_of(state)];

  always_comb begin
    state_nx    = state;
    wr_allow    = 1'b0;
    cmd_nostore = 1'b0;
    dummy_start = 1'b0;
    load_close  = 1'b0;
    case (state)
      S_IDLE: if (wr_evt) begin
        if (slot_ok) begin
          cmd_nostore = 1'b1;
          state_nx    = seq_advance(state);
        end else begin
          dummy_start = 1'b1;
          state_nx    = S_BUSY;
        end
      end
      S_GOT1, S_GOT2: if (wr_evt) begin
        if (slot_ok) begin
          cmd_nostore = 1'b1;
          state_nx    = seq_advance(state);
        end else begin
          state_nx    = S_IDLE;
        end
      end
      S_OPEN: begin
        if (wr_evt) begin
          wr_allow = 1'b1;
          state_nx = S_LOAD;
        end else if (win_expire) begin
          state_nx = S_IDLE;
        end
      end
      S_LOAD: begin
        if (wr_evt) begin
          wr_allow = 1'b1;
        end else if (win_expire) begin
          load_close = 1'b1;
          state_nx   = S_BUSY;
        end
      end
      S_BUSY: if (prog_done) state_nx = S_IDLE;
      default: state_nx = S_IDLE;
    endcase
  end

  assign poll_busy = (state == S_BUSY);

  always_ff @(posedge clk) begin
    if (!rst_n) state <= S_IDLE;
    else        state <= state_nx;
  end

  AST_OUT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_allow, cmd_nostore, dummy_start, load_close}));   // R2
  AST_EVT_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_allow || cmd_nostore || dummy_start) |-> wr_evt);          // R4
  AST_DUMMY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    dummy_start |=> poll_busy);                                    // R5
  AST_BUSY_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    poll_busy |-> !(wr_allow || cmd_nostore || dummy_start || load_close)); // R6
  AST_DONE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (poll_busy && prog_done) |=> !poll_busy);                      // R6
  AST_CLOSE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    load_close |=> poll_busy);                                     // R7
  AST_ALLOW_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    wr_allow |=> !poll_busy);                                      // R11
  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (poll_busy && !prog_done) |=> poll_busy);                      // R10

endmodule

// File: tb/test_wp_unlock_seq.sv
module test_wp_unlock_seq;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 17;
  localparam int DW = 8;
  localparam int LW = 16;

  localparam logic [AW-1:0] A0 = 17'h05555, A1 = 17'h02AAA, A2 = 17'h05555;
  localparam logic [DW-1:0] D0 = 8'hAA, D1 = 8'h55, D2 = 8'hA0;

  // expected bits: {allow, cmd, dummy, close, busy}
  typedef struct packed {
    logic          evt;
    logic          done;
    logic [AW-1:0] addr;
    logic [DW-1:0] data;
    logic [4:0]    exp;
    logic [3:0]    req;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b0, 17'h0,     8'h00, 5'b00000, 4'd1},  // R1 idle after reset
    '{1'b1, 1'b0, A0,        D0,    5'b01000, 4'd2},  // R2 first command
    '{1'b1, 1'b0, A1,        8'h00, 5'b00000, 4'd3},  // R3 bad second slot
    '{1'b1, 1'b0, A1,        D1,    5'b00100, 4'd3},  // R3 restart needed -> R5 dummy
    '{1'b0, 1'b0, 17'h0,     8'h00, 5'b00001, 4'd10}, // R10 busy
    '{1'b1, 1'b0, 17'h00010, 8'h77, 5'b00001, 4'd6},  // R6 ignored
    '{1'b1, 1'b0, A0,        D0,    5'b00001, 4'd6},  // R6 command ignored
    '{1'b0, 1'b1, 17'h0,     8'h00, 5'b00001, 4'd10}, // R10 busy until done
    '{1'b0, 1'b0, 17'h0,     8'h00, 5'b00000, 4'd6},  // R6 released
    '{1'b1, 1'b0, A0,        D0,    5'b01000, 4'd2},  // R2
    '{1'b1, 1'b0, A1,        D1,    5'b01000, 4'd2},  // R2
    '{1'b1, 1'b0, A0,        D0,    5'b00000, 4'd3},  // R3 bad third slot
    '{1'b1, 1'b0, A0,        D0,    5'b01000, 4'd2},  // R2 restart
    '{1'b1, 1'b0, A1,        D1,    5'b01000, 4'd2},  // R2
    '{1'b1, 1'b0, A2,        D2,    5'b01000, 4'd2},  // R2 third command
    '{1'b1, 1'b0, 17'h00100, 8'h3C, 5'b10000, 4'd4},  // R4 data write
    '{1'b1, 1'b0, A0,        D0,    5'b10000, 4'd4},  // R4 command address stored
    '{1'b0, 1'b1, 17'h0,     8'h00, 5'b00000, 4'd6}   // R6 done ignored while loading
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_evt = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic prog_done = 1'b0;
  logic wr_allow, cmd_nostore, dummy_start, load_close, poll_busy;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wp_unlock_seq #(.AW(AW), .DW(DW), .LOAD_WIN(LW)) i_wp_unlock_seq (
    .clk(clk), .rst_n(rst_n), .wr_evt(wr_evt), .wr_addr(wr_addr),
    .wr_data(wr_data), .prog_done(prog_done), .wr_allow(wr_allow),
    .cmd_nostore(cmd_nostore), .dummy_start(dummy_start),
    .load_close(load_close), .poll_busy(poll_busy)
  );

  // Drive at a falling edge, sample 1 time unit later, advance to next falling edge.
  task automatic step(input logic evt, input logic done, input logic [AW-1:0] a,
                      input logic [DW-1:0] d, input logic [4:0] exp, input string req);
    logic [4:0] act;
    wr_evt = evt; prog_done = done; wr_addr = a; wr_data = d;
    #1;
    act = {wr_allow, cmd_nostore, dummy_start, load_close, poll_busy};
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: {allow,cmd,dummy,close,busy} actual %b expected %b at %0t",
               req, act, exp, $time);
    end
    @(negedge clk);
  endtask

  task automatic idle(input logic [4:0] exp, input string req);
    step(1'b0, 1'b0, '0, '0, exp, req);
  endtask

  task automatic unlock();
    step(1'b1, 1'b0, A0, D0, 5'b01000, "R2");
    step(1'b1, 1'b0, A1, D1, 5'b01000, "R2");
    step(1'b1, 1'b0, A2, D2, 5'b01000, "R2");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++)
      step(VECS[i].evt, VECS[i].done, VECS[i].addr, VECS[i].data, VECS[i].exp,
           $sformatf("R%0d", VECS[i].req));

    // R7: step 17 above was idle cycle 1 of the window
    for (int k = 2; k < LW; k++) idle(5'b00000, "R7");
    idle(5'b00010, "R7");
    idle(5'b00001, "R10");
    step(1'b1, 1'b0, 17'h00200, 8'h11, 5'b00001, "R6");
    step(1'b0, 1'b1, '0, '0, 5'b00001, "R6");
    // R9: protection is back after programming
    step(1'b1, 1'b0, 17'h00200, 8'h11, 5'b00100, "R9");
    step(1'b0, 1'b1, '0, '0, 5'b00001, "R9");

    // R8: unlocked but no data write in the window
    unlock();
    for (int k = 1; k <= LW; k++) idle(5'b00000, "R8");
    step(1'b1, 1'b0, 17'h00300, 8'h22, 5'b00100, "R8");
    step(1'b0, 1'b1, '0, '0, 5'b00001, "R8");

    // R11: a second write restarts the window
    unlock();
    step(1'b1, 1'b0, 17'h00400, 8'h33, 5'b10000, "R11");
    for (int k = 1; k <= LW - 2; k++) idle(5'b00000, "R11");
    step(1'b1, 1'b0, 17'h00401, 8'h34, 5'b10000, "R11");
    for (int k = 1; k <= LW - 1; k++) idle(5'b00000, "R11");
    idle(5'b00010, "R11");
    step(1'b0, 1'b1, '0, '0, 5'b00001, "R10");

    // R1: reset in the middle of a sequence
    step(1'b1, 1'b0, A0, D0, 5'b01000, "R1");
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    idle(5'b00000, "R1");
    step(1'b1, 1'b0, A1, D1, 5'b00100, "R1");
    step(1'b0, 1'b1, '0, '0, 5'b00001, "R1");
    idle(5'b00000, "R1");

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule